// File: doc/BRIEF.md
# Lane Test Pattern Generator

This block produces the transmit stream for one lane of a multi-lane serial link tester. Every clock it presents a 16-bit word (two bytes, low byte sent first) with one control flag per byte, ready for a downstream 8b/10b encoder. A 3-bit select picks one of eight test patterns:

- byte-wise counters, up and down
- word-wise counters, up and down
- three constant patterns
- a PRBS built on the x^7+x^6+1 polynomial

A comma word is inserted when the lane starts and at a fixed interval after that, so the receiver can find byte boundaries.

For crosstalk stress, aggressor mode bypasses the line code. In this mode the lane drives a raw 20-bit word that alternates each clock between all ones and all zeros, and it raises an encoder-bypass select. Transmit inhibit silences the lane while it is asserted. All outputs are registered: inputs sampled at one rising edge determine the outputs that follow that edge.

Top module: `lane_pattern_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every output is zero.
- R2: On the first enabled cycle after the lane was disabled, the lane sends a comma word: tx_data = 0xC5BC (K28.5 = 0xBC in the low byte, filler 0xC5 in the high byte) with tx_k = 2'b01. The pattern then starts from its seed.
- R3: After a restart, a comma word is sent every 256 words: at offsets 256, 512 and so on. The pattern position does not advance during a comma cycle, and tx_k is nonzero only on comma words.
- R4: Select 0 (byte up-count) sends {2n+1, 2n}; select 1 (byte down-count) sends {254-2n, 255-2n}. Here n is the pattern-word index since the restart, and all values are taken modulo 256.
- R5: Select 2 sends the 16-bit word n. Select 3 sends 0xFFFF-n, modulo 2^16.
- R6: Select 4 sends 0x0000, select 5 sends 0xFFFF and select 6 sends 0xFF00.
- R7: Select 7 sends PRBS bits 16n to 16n+15, with the earliest bit in bit 0. The sequence follows p[k] = p[k-7] XOR p[k-6], with the seven bits before p[0] all equal to one.
- R8: A change of the select while the lane is enabled counts as a restart. The lane sends a comma word and then the new pattern from index 0.
- R9: With the lane enabled, aggressor mode on and inhibit off, the outputs are as follows. bypass is 1 and tx_data and tx_k are zero. raw_word is 0xFFFFF on the first aggressor cycle and inverts on every following cycle. In all other cycles raw_word and bypass are zero.
- R10: While tx_inhibit is asserted, tx_data, tx_k, raw_word and bypass are all zero. Pattern position and comma spacing continue to advance.
- R11: While en is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Lane enable |
| pat_sel | input | 3 | Test pattern select |
| aggr_en | input | 1 | Aggressor mode |
| tx_inhibit | input | 1 | Silence the lane |
| tx_data | output | 16 | Two data bytes, low byte first |
| tx_k | output | 2 | Control-character flag per byte |
| raw_word | output | 20 | Unencoded aggressor word |
| bypass | output | 1 | Select the raw word instead of the encoder output |

## Verification
A select change and the periodic comma can fall in the same cycle, and so can an inhibit and a comma. In both cases the outcome must still be a single comma, and the pattern index must restart or hold as the requirements state. The bench drives long runs that cross the 256-word boundary and changes the select exactly on comma slots and next to them. It also lays random inhibit and aggressor pulses over those slots. A reference model built from word indices, not from shift registers, judges every cycle.

// File: rtl/lane_pattern_gen.sv
module lane_pattern_gen #(
  parameter int CNT_W = 8,
  parameter logic [6:0] PRBS_SEED = 7'h7F,
  parameter logic [7:0] COMMA_CHAR = 8'hBC,
  parameter logic [7:0] COMMA_FILL = 8'hC5,
  parameter int RAW_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [2:0]       pat_sel,
  input  logic             aggr_en,
  input  logic             tx_inhibit,
  output logic [15:0]      tx_data,
  output logic [1:0]       tx_k,
  output logic [RAW_W-1:0] raw_word,
  output logic             bypass
);

  localparam logic [15:0] COMMA_WORD = {COMMA_FILL, COMMA_CHAR};

  logic             en_q;
  logic [2:0]       sel_q;
  logic [CNT_W-1:0] gap_cnt;
  logic [15:0]      st;
  logic             ph;

  wire restart = en && (!en_q || pat_sel != sel_q);
  wire comma   = restart || gap_cnt == '0;
  wire live    = en && !tx_inhibit;

  function automatic logic [22:0] prbs16(input logic [6:0] s);
    logic [6:0]  r;
    logic [15:0] w;
    logic        b;
    r = s;
    w = '0;
    for (int i = 0; i < 16; i++) begin
      b    = r[6] ^ r[5];
      r    = {r[5:0], b};
      w[i] = b;
    end
    return {r, w};
  endfunction

  function automatic logic [15:0] seed_of(input logic [2:0] s);
    case (s)
      3'd1:    return 16'h00FF;
      3'd3:    return 16'hFFFF;
      3'd7:    return {9'd0, PRBS_SEED};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] word_of(input logic [2:0] s, input logic [15:0] v);
    logic [22:0] p;
    p = prbs16(v[6:0]);
    case (s)
      3'd0:    return {v[7:0] + 8'd1, v[7:0]};
      3'd1:    return {v[7:0] - 8'd1, v[7:0]};
      3'd2:    return v;
      3'd3:    return v;
      3'd4:    return 16'h0000;
      3'd5:    return 16'hFFFF;
      3'd6:    return 16'hFF00;
      default: return p[15:0];
    endcase
  endfunction

  function automatic logic [15:0] next_of(input logic [2:0] s, input logic [15:0] v);
    logic [22:0] p;
    p = prbs16(v[6:0]);
    case (s)
      3'd0:    return {8'd0, v[7:0] + 8'd2};
      3'd1:    return {8'd0, v[7:0] - 8'd2};
      3'd2:    return v + 16'd1;
      3'd3:    return v - 16'd1;
      3'd7:    return {9'd0, p[22:16]};
      default: return v;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      sel_q   <= '0;
      gap_cnt <= '0;
      st      <= '0;
      ph      <= 1'b1;
    end else begin
      en_q  <= en;
      sel_q <= pat_sel;
      ph    <= (en && aggr_en) ? ~ph : 1'b1;
      if (!en) begin
        gap_cnt <= '0;
      end else if (restart) begin
        gap_cnt <= CNT_W'(1);
        st      <= seed_of(pat_sel);
      end else begin
        gap_cnt <= gap_cnt + 1'b1;
        if (!comma) st <= next_of(pat_sel, st);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !live) begin
      tx_data  <= '0;
      tx_k     <= '0;
      raw_word <= '0;
      bypass   <= 1'b0;
    end else if (aggr_en) begin
      tx_data  <= '0;
      tx_k     <= '0;
      raw_word <= ph ? '1 : '0;
      bypass   <= 1'b1;
    end else begin
      tx_data  <= comma ? COMMA_WORD : word_of(pat_sel, st);
      tx_k     <= comma ? 2'b01 : 2'b00;
      raw_word <= '0;
      bypass   <= 1'b0;
    end
  end

  AST_RAW_ONLY_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass |-> raw_word == '0);                                          // R9
  AST_AGGR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    bypass && $past(bypass) |-> raw_word == ~$past(raw_word));             // R9
  AST_K_ONLY_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    tx_k != 2'b00 |-> tx_k == 2'b01 && tx_data == COMMA_WORD);             // R3
  AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_inhibit) |-> tx_data == '0 && tx_k == '0 && !bypass);         // R10
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> tx_data == '0 && raw_word == '0 && !bypass);            // R11
  AST_START_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) && !$past(en, 2) && !$past(tx_inhibit) && !$past(aggr_en)
      |-> tx_k == 2'b01);                                                  // R2

endmodule

// File: tb/lane_pattern_gen_test.sv
`timescale 1ns/1ps
module lane_pattern_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [2:0] pat_sel = '0;
  logic aggr_en = 1'b0;
  logic tx_inhibit = 1'b0;
  logic [15:0] tx_data;
  logic [1:0] tx_k;
  logic [19:0] raw_word;
  logic bypass;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit prbs_bits [0:16399];
  bit m_en_q = 0;
  logic [2:0] m_sel_q = '0;
  int m_cnt = 0;
  int m_pos = 0;
  bit m_ph = 1;

  always #2.5 clk = ~clk;

  lane_pattern_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .pat_sel(pat_sel), .aggr_en(aggr_en),
    .tx_inhibit(tx_inhibit), .tx_data(tx_data), .tx_k(tx_k),
    .raw_word(raw_word), .bypass(bypass));

  function automatic logic [15:0] exp_word(input logic [2:0] s, input int n);
    logic [15:0] w;
    case (s)
      3'd0: w = {8'(2*n + 1), 8'(2*n)};
      3'd1: w = {8'(254 - 2*n), 8'(255 - 2*n)};
      3'd2: w = 16'(n);
      3'd3: w = 16'(65535 - n);
      3'd4: w = 16'h0000;
      3'd5: w = 16'hFFFF;
      3'd6: w = 16'hFF00;
      default: begin
        for (int i = 0; i < 16; i++) w[i] = prbs_bits[16*n + i];
      end
    endcase
    return w;
  endfunction

  function automatic string pat_req(input logic [2:0] s);
    if (s <= 3'd1) return "R4";
    if (s <= 3'd3) return "R5";
    if (s <= 3'd6) return "R6";
    return "R7";
  endfunction

  task automatic compare(input string req, input logic [15:0] ed, input logic [1:0] ek,
                         input logic [19:0] er, input logic eb);
    checks++;
    if (tx_data !== ed || tx_k !== ek || raw_word !== er || bypass !== eb) begin
      errors++;
      $display("FAIL %s: got data=%h k=%b raw=%h byp=%b, expected data=%h k=%b raw=%h byp=%b",
               req, tx_data, tx_k, raw_word, bypass, ed, ek, er, eb);
    end
  endtask

  task automatic step(input bit e, input logic [2:0] s, input bit a, input bit inh);
    bit restart, comma, selchg;
    logic [15:0] ed;
    logic [1:0] ek;
    logic [19:0] er;
    logic eb;
    string req;
    en = e; pat_sel = s; aggr_en = a; tx_inhibit = inh;
    selchg  = e && m_en_q && s != m_sel_q;
    restart = e && (!m_en_q || s != m_sel_q);
    comma   = restart || (e && m_cnt == 0);
    ed = '0; ek = '0; er = '0; eb = 0;
    if (!e) req = "R11";
    else if (inh) req = "R10";
    else if (a) begin
      req = "R9"; eb = 1; er = m_ph ? 20'hFFFFF : 20'h0;
    end else if (comma) begin
      req = selchg ? "R8" : (restart ? "R2" : "R3");
      ed = 16'hC5BC; ek = 2'b01;
    end else begin
      req = pat_req(s);
      ed = exp_word(s, m_pos);
    end
    m_ph = (e && a) ? !m_ph : 1;
    if (!e) m_cnt = 0;
    else if (restart) begin m_cnt = 1; m_pos = 0; end
    else begin
      if (m_cnt != 0) m_pos++;
      m_cnt = (m_cnt + 1) % 256;
    end
    m_en_q = e; m_sel_q = s;
    @(negedge clk);
    compare(req, ed, ek, er, eb);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit q [0:16406];
    for (int i = 0; i < 7; i++) q[i] = 1;
    for (int k = 0; k < 16400; k++) begin
      q[k+7] = q[k] ^ q[k+1];
      prbs_bits[k] = q[k+7];
    end
    void'($urandom(32'd9157));

    @(negedge clk);
    compare("R1", 16'h0, 2'b0, 20'h0, 1'b0);
    repeat (3) @(negedge clk);
    compare("R1", 16'h0, 2'b0, 20'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1", 16'h0, 2'b0, 20'h0, 1'b0);

    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 530; c++) step(1, 3'(p), 0, 0);
      step(0, 3'(p), 0, 0);
      step(0, 3'(p), 0, 0);
    end
    for (int c = 0; c < 256; c++) step(1, 3'd2, 0, 0);
    step(1, 3'd7, 0, 0);
    for (int c = 0; c < 255; c++) step(1, 3'd7, 0, 0);
    step(1, 3'd0, 0, 0);
    for (int c = 0; c < 254; c++) step(1, 3'd0, 0, 0);
    step(1, 3'd0, 0, 1);
    step(1, 3'd0, 0, 0);
    for (int c = 0; c < 12; c++) step(1, 3'd3, 1, 0);
    step(1, 3'd3, 1, 1);
    step(1, 3'd3, 1, 0);
    step(0, 3'd3, 1, 0);
    step(1, 3'd3, 1, 0);
    step(1, 3'd3, 0, 0);

    for (int c = 0; c < 20000; c++) begin
      bit e, a, inh;
      logic [2:0] s;
      e   = ($urandom % 100) < 95;
      a   = ($urandom % 100) < 6;
      inh = ($urandom % 100) < 6;
      s   = m_sel_q;
      if (($urandom % 100) < 2 || m_pos > 900 || (m_cnt == 0 && ($urandom % 4) == 0))
        s = 3'($urandom % 8);
      step(e, s, a, inh);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule